// File: doc/BRIEF.md
# Paged Effective Address Generator

This block turns the addressing fields of a decoded data-access instruction into a final 15-bit memory address for a small 8-bit processor. The address space is cut into four pages of 8 KiB. The upper two address bits select the page, and the lower 13 bits are the offset within it. A direct access always stays in the page the program counter currently points into. Only an indirect access can reach another page, because the pointer it reads carries its own page bits.

The caller presents a request for one cycle: the address of the instruction (used as the program counter), a relative/absolute select, an indirect flag, an index operation, whether the destination register is r0, the operand bytes and the current value of the chosen index register. A direct request completes on the next clock. An indirect request first reads a two-byte pointer through a simple read port whose data returns one clock after the read strobe. Index adjustment (plain, pre-increment or pre-decrement) is applied last, on top of either the direct address or the fetched pointer. The adjusted index value is returned so the register file can write it back.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done`, `busy`, `illegal`, `idx_we` and `mem_rd` are all 0.
- R2: An absolute direct request (`rel_mode`=0, `indirect`=0) accepted on a clock edge gives `done`=1 after that edge, with `ea` = {`pc`[14:13], {`opnd_hi`,`opnd_lo`}[12:0]}. The page bits come from `pc`.
- R3: A relative direct request gives `ea` = {`pc`[14:13], (`pc`[12:0] + sign-extended `opnd_lo`[6:0]) mod 8192}. `opnd_lo`[7] and `opnd_hi` have no effect.
- R4: An indirect request computes the same base address as R2/R3 and reads memory twice: first at the base, then at the base offset plus one, wrapped mod 8192 within the same page. The first byte is the high byte. The pointer is {high[6:0], low}, and `done` rises after the fourth clock edge counted from the accepting edge.
- R5: `idx_op` encodes 0 = no index, 1 = add index, 2 = pre-increment, 3 = pre-decrement. The adjusted index wraps mod 256. For codes 2 and 3, `idx_we` pulses together with `done` and `idx_new` holds the adjusted value. For codes 0 and 1, `idx_we` stays 0.
- R6: For `idx_op` codes 1 to 3, the adjusted index (zero-extended) is added to the 13-bit offset of the address after any indirect lookup, mod 8192, and the page bits are kept.
- R7: A request with `idx_op`≠0 and `dest_r0`=0 is illegal. `done` and `illegal` rise after the accepting edge, no memory read is made and `idx_we` stays 0.
- R8: `busy` is 1 from the accepting edge of a legal indirect request until `done`. While `busy` is 1, `done` is 0, and `req_valid` and all request fields are ignored.
- R9: `mem_rd` is asserted only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, taken when not busy |
| pc | input | 15 | Address of the current instruction |
| rel_mode | input | 1 | 1 = relative displacement, 0 = absolute offset |
| indirect | input | 1 | Resolve through a two-byte pointer |
| idx_op | input | 2 | Index operation code (see R5) |
| dest_r0 | input | 1 | Destination register is r0 |
| opnd_hi | input | 8 | First operand byte (absolute high part) |
| opnd_lo | input | 8 | Second operand byte or displacement |
| idx_val | input | 8 | Current value of the selected index register |
| busy | output | 1 | Indirect resolution in progress |
| done | output | 1 | One-cycle strobe: result valid |
| ea | output | 15 | Effective address |
| idx_new | output | 8 | Adjusted index register value |
| idx_we | output | 1 | Write back `idx_new` to the index register |
| illegal | output | 1 | Request rejected (index with non-r0 destination) |
| mem_rd | output | 1 | Pointer read strobe |
| mem_addr | output | 15 | Pointer read address |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_rd` |

## Verification
Relative requests are swept over every displacement byte, from pc offsets at 0, 8191 and mid-page, in all four pages. This separates correct sign extension and in-page wrap from a carry that leaks into the page bits or a use of bit 7. Absolute requests with all-ones operands show that the upper operand bits are dropped. Indirect requests placed at the last byte of a page show the second pointer read wrapping inside the page, and a content-dependent memory shows the byte order and the masking of the pointer's top bit. Every index code is combined with direct and indirect forms, with index values 0, 1, 0x7F and 0xFF and with both destination settings. Together these separate the order of adjust-then-add, the 8-bit wrap of increment and decrement, the write-back strobe and the illegal reject. Scrambled requests are driven while the block is busy to show they are ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int ADDR_W = 15;
    localparam int PAGE_W = 2;
    localparam int OFF_W  = ADDR_W - PAGE_W;
    localparam int DATA_W = 8;
    localparam int DISP_W = 7;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_ADD  = 2'd1,
        IDX_INC  = 2'd2,
        IDX_DEC  = 2'd3
    } idx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PTR_HI,
        ST_PTR_LO,
        ST_FINISH
    } ea_state_e;

    // Add an offset inside the page of 'a'; page bits never change.
    function automatic addr_t in_page_add(addr_t a, off_t d);
        off_t o;
        o = a[OFF_W-1:0] + d;
        return {a[ADDR_W-1:OFF_W], o};
    endfunction
endpackage

// File: rtl/ea_base.sv
module ea_base
    import ea_pkg::*;
(
    input  addr_t pc,
    input  logic  rel_mode,
    input  byte_t opnd_hi,
    input  byte_t opnd_lo,
    output addr_t base
);
    localparam int EXT_W = OFF_W - DISP_W;

    logic [2*DATA_W-1:0] both;
    off_t                disp;
    off_t                abs_off;
    logic                unused_bits;

    assign both        = {opnd_hi, opnd_lo};
    assign abs_off     = both[OFF_W-1:0];
    assign disp        = {{EXT_W{opnd_lo[DISP_W-1]}}, opnd_lo[DISP_W-1:0]};
    assign unused_bits = ^both[2*DATA_W-1:OFF_W];

    always_comb begin
        if (rel_mode) base = in_page_add(pc, disp);
        else          base = {pc[ADDR_W-1:OFF_W], abs_off};
    end
endmodule

// File: rtl/ea_index.sv
module ea_index
    import ea_pkg::*;
(
    input  idx_op_e op,
    input  byte_t   idx_val,
    input  addr_t   addr_in,
    output byte_t   idx_adj,
    output addr_t   addr_out,
    output logic    idx_write
);
    always_comb begin
        case (op)
            IDX_INC: idx_adj = idx_val + byte_t'(1);
            IDX_DEC: idx_adj = idx_val - byte_t'(1);
            default: idx_adj = idx_val;
        endcase
        if (op == IDX_NONE) addr_out = addr_in;
        else                addr_out = in_page_add(addr_in, off_t'(idx_adj));
        idx_write = (op == IDX_INC) || (op == IDX_DEC);
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [14:0] pc,
    input  logic        rel_mode,
    input  logic        indirect,
    input  logic [1:0]  idx_op,
    input  logic        dest_r0,
    input  logic [7:0]  opnd_hi,
    input  logic [7:0]  opnd_lo,
    input  logic [7:0]  idx_val,
    output logic        busy,
    output logic        done,
    output logic [14:0] ea,
    output logic [7:0]  idx_new,
    output logic        idx_we,
    output logic        illegal,
    output logic        mem_rd,
    output logic [14:0] mem_addr,
    input  logic [7:0]  mem_rdata
);
    ea_state_e state;
    addr_t     ptr_addr;
    logic [DATA_W-2:0] ptr_hi;
    idx_op_e   op_q;
    byte_t     idx_q;

    addr_t   base;
    idx_op_e op_in;
    idx_op_e ix_op;
    byte_t   ix_val;
    addr_t   ix_addr_in;
    byte_t   ix_adj;
    addr_t   ix_addr;
    logic    ix_we;
    logic    bad_req;

    assign op_in   = idx_op_e'(idx_op);
    assign bad_req = (op_in != IDX_NONE) && !dest_r0;

    ea_base u_base (
        .pc      (pc),
        .rel_mode(rel_mode),
        .opnd_hi (opnd_hi),
        .opnd_lo (opnd_lo),
        .base    (base)
    );

    // The index unit serves the direct path from the request and the
    // indirect path from the latched request plus the fetched pointer.
    always_comb begin
        if (state == ST_FINISH) begin
            ix_op      = op_q;
            ix_val     = idx_q;
            ix_addr_in = {ptr_hi, mem_rdata};
        end else begin
            ix_op      = op_in;
            ix_val     = idx_val;
            ix_addr_in = base;
        end
    end

    ea_index u_index (
        .op       (ix_op),
        .idx_val  (ix_val),
        .addr_in  (ix_addr_in),
        .idx_adj  (ix_adj),
        .addr_out (ix_addr),
        .idx_write(ix_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            illegal  <= 1'b0;
            idx_we   <= 1'b0;
            ea       <= '0;
            idx_new  <= '0;
            ptr_addr <= '0;
            ptr_hi   <= '0;
            op_q     <= IDX_NONE;
            idx_q    <= '0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            idx_we  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (bad_req) begin
                            done    <= 1'b1;
                            illegal <= 1'b1;
                        end else if (indirect) begin
                            ptr_addr <= base;
                            op_q     <= op_in;
                            idx_q    <= idx_val;
                            state    <= ST_PTR_HI;
                        end else begin
                            done    <= 1'b1;
                            ea      <= ix_addr;
                            idx_new <= ix_adj;
                            idx_we  <= ix_we;
                        end
                    end
                end
                ST_PTR_HI: state <= ST_PTR_LO;
                ST_PTR_LO: begin
                    ptr_hi <= mem_rdata[DATA_W-2:0];
                    state  <= ST_FINISH;
                end
                ST_FINISH: begin
                    done    <= 1'b1;
                    ea      <= ix_addr;
                    idx_new <= ix_adj;
                    idx_we  <= ix_we;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign mem_rd   = (state == ST_PTR_HI) || (state == ST_PTR_LO);
    assign mem_addr = (state == ST_PTR_LO) ? in_page_add(ptr_addr, off_t'(1)) : ptr_addr;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
    import ea_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [14:0] pc,
    input logic        indirect,
    input logic [1:0]  idx_op,
    input logic        dest_r0,
    input logic        busy,
    input logic        done,
    input logic [14:0] ea,
    input logic        illegal,
    input logic        idx_we,
    input logic        mem_rd,
    input logic [14:0] mem_addr
);
    // R8
    busy_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R9
    rd_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

    // R7
    illegal_clean_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && !idx_we));

    // R5
    we_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        idx_we |-> done);

    // R2
    page_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !indirect && (idx_op == 2'd0 || dest_r0))
        |=> (done && ea[ADDR_W-1:OFF_W] == $past(pc[ADDR_W-1:OFF_W])));

    // R7
    illegal_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && idx_op != 2'd0 && !dest_r0)
        |=> (done && illegal && !mem_rd));

    // R4
    second_read_page_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd))
        |-> (mem_addr == in_page_add($past(mem_addr), off_t'(1))));
endmodule

bind ea_gen ea_gen_chk u_chk (.*);

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [14:0] pc = '0;
    logic        rel_mode = 1'b0;
    logic        indirect = 1'b0;
    logic [1:0]  idx_op = '0;
    logic        dest_r0 = 1'b1;
    logic [7:0]  opnd_hi = '0;
    logic [7:0]  opnd_lo = '0;
    logic [7:0]  idx_val = '0;
    logic        busy, done, idx_we, illegal, mem_rd;
    logic [14:0] ea, mem_addr;
    logic [7:0]  idx_new;
    logic [7:0]  mem_rdata = '0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ea_gen u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .pc(pc),
        .rel_mode(rel_mode), .indirect(indirect), .idx_op(idx_op),
        .dest_r0(dest_r0), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
        .idx_val(idx_val), .busy(busy), .done(done), .ea(ea),
        .idx_new(idx_new), .idx_we(idx_we), .illegal(illegal),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mbyte(input logic [14:0] a);
        int v;
        v = int'(a);
        return 8'(((v * 7) + (v >>> 8)) ^ 'h5A);
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mbyte(mem_addr);

    function automatic int base_of(input int p, input bit rl, input int h, input int l);
        int off;
        if (rl) begin
            off = (p & 8191) + (((l & 64) != 0) ? (l & 127) - 128 : (l & 127));
            off = off & 8191;
        end else begin
            off = ((h << 8) | l) & 8191;
        end
        return (p & 'h6000) | off;
    endfunction

    function automatic int adj_of(input int op, input int x);
        if (op == 2) return (x + 1) & 255;
        if (op == 3) return (x + 255) & 255;
        return x;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic run(input int p, input bit rl, input bit ind, input int op,
                       input bit r0, input int h, input int l, input int x);
        int lat = 0;
        int nrd = 0;
        int rd0 = 0;
        int rd1 = 0;
        int b, b2, e, adj, ptr;
        bit legal;
        logic [14:0] c_ea;
        logic [7:0] c_new;
        logic c_we, c_ill;
        @(negedge clk);
        pc = 15'(p); rel_mode = rl; indirect = ind; idx_op = 2'(op);
        dest_r0 = r0; opnd_hi = 8'(h); opnd_lo = 8'(l); idx_val = 8'(x);
        req_valid = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (mem_rd) begin
                if (nrd == 0) rd0 = int'(mem_addr); else rd1 = int'(mem_addr);
                nrd++;
            end
            if (done) begin
                lat = k;
                break;
            end
            // scrambled request while busy: must be ignored (R8)
            req_valid = 1'b1; pc = ~pc; rel_mode = ~rl; indirect = ~ind;
            idx_op = 2'd3; dest_r0 = 1'b0; opnd_hi = ~opnd_hi; opnd_lo = ~opnd_lo;
            idx_val = ~idx_val;
        end
        c_ea = ea; c_new = idx_new; c_we = idx_we; c_ill = illegal;
        req_valid = 1'b0;

        legal = (op == 0) || r0;
        b   = base_of(p, rl, h, l);
        b2  = (b & 'h6000) | ((b + 1) & 8191);
        adj = adj_of(op, x);
        if (ind) begin
            ptr = ((int'(mbyte(15'(b))) & 127) << 8) | int'(mbyte(15'(b2)));
        end else begin
            ptr = b;
        end
        e = ptr;
        if (op != 0) e = (ptr & 'h6000) | ((ptr + adj) & 8191);

        chk(c_ill == !legal, "R7 illegal flag", int'(c_ill), int'(!legal));
        if (!legal) begin
            chk(lat == 1 && nrd == 0 && !c_we, "R7 reject timing/no read/no write",
                lat * 100 + nrd * 10 + int'(c_we), 100);
        end else begin
            chk(lat == (ind ? 4 : 1), ind ? "R4 R8 indirect latency" : "R2 direct latency",
                lat, ind ? 4 : 1);
            chk(int'(c_ea) == e,
                ind ? "R4 R6 R8 indirect address" : (rl ? "R3 R6 relative address" : "R2 R6 absolute address"),
                int'(c_ea), e);
            if (ind) chk(nrd == 2 && rd0 == b && rd1 == b2, "R4 pointer read addresses",
                         rd0 * 65536 + rd1, b * 65536 + b2);
            else     chk(nrd == 0, "R9 no read on direct", nrd, 0);
            chk(c_we == (op >= 2), "R5 write-back strobe", int'(c_we), int'(op >= 2));
            if (op >= 2) chk(int'(c_new) == adj, "R5 adjusted index", int'(c_new), adj);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int offs[3];
        int hv[4];
        int lv[3];
        int xv[4];
        offs = '{0, 8191, 4096};
        hv = '{'h00, 'h1F, 'hFF, 'hA5};
        lv = '{'h00, 'hFF, 'h3C};
        xv = '{0, 1, 'h7F, 'hFF};

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 state during and right after reset
        chk(!done && !busy && !illegal && !idx_we && !mem_rd, "R1 outputs in reset",
            {27'd0, done, busy, illegal, idx_we, mem_rd}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !busy && !illegal && !idx_we && !mem_rd, "R1 outputs after reset",
            {27'd0, done, busy, illegal, idx_we, mem_rd}, 0);

        // R2 absolute, every page, operand corners
        for (int pg = 0; pg < 4; pg++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 3; j++)
                    run(pg * 8192 + 'h0123 * (i + 1), 1'b0, 1'b0, 0, 1'b1, hv[i], lv[j], 0);

        // R3 relative, full displacement byte sweep at page edges
        for (int pg = 0; pg < 4; pg++)
            for (int o = 0; o < 3; o++)
                for (int d = 0; d < 256; d++)
                    run(pg * 8192 + offs[o], 1'b1, 1'b0, 0, 1'b1, 'hC3, d, 0);

        // R4 R6 indirect with every index code, incl. pointer at page end
        for (int pg = 0; pg < 4; pg++)
            for (int o = 0; o < 3; o++)
                for (int op = 0; op < 4; op++)
                    for (int xi = 0; xi < 4; xi += 3) begin
                        run(pg * 8192 + 'h0777, 1'b0, 1'b1, op, 1'b1,
                            offs[o] >> 8, offs[o] & 255, xv[xi]);
                        run(pg * 8192 + offs[o], 1'b1, 1'b1, op, 1'b1, 0, 'h7F, xv[xi]);
                    end

        // R5 R6 R7 index codes x destination x values, direct and indirect
        for (int ind = 0; ind < 2; ind++)
            for (int op = 0; op < 4; op++)
                for (int r0 = 0; r0 < 2; r0++)
                    for (int xi = 0; xi < 4; xi++)
                        for (int o = 0; o < 3; o++)
                            run('h4000 + 'h0ABC, 1'b0, 1'(ind), op, 1'(r0),
                                (offs[o] ^ 'h0F0) >> 8, (offs[o] ^ 'h0F0) & 255, xv[xi]);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule